// File: doc/BRIEF.md
# Banked Tristate Output Enable Control

This block decides, for each of the twelve bidirectional pins of one logic block, whether the pin's three-state driver is active. Four output-enable terms come in, already evaluated by the logic array. The pins form two banks of six, and each bank owns two of the four terms. Each pin carries a two-bit mode. The mode can hold the driver off, hold it on, or let it follow one of the two terms of the pin's own bank.

Enables are registered, so they take effect one clock after the mode and term values that produce them. The pad itself is modelled as an inout. While a pin is enabled it drives its macrocell output value. While it is disabled it floats to high impedance. In both cases the value on the pad is returned on a feedback output. A disabled pin therefore works as an input, and a pin whose enable comes from a term works as a bus-driving or bidirectional line.

Top module: `banked_oe_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `pin_oe` is 0 after that edge, and every pad is released to high impedance.
- R2: A pin with mode 2'b00 has its enable at 0 after the next rising edge.
- R3: A pin with mode 2'b01 has its enable at 1 after the next rising edge.
- R4: A pin with mode 2'b10 takes the first term of its bank after the next rising edge. That term is `oe_term[0]` for pins 0 to 5 and `oe_term[2]` for pins 6 to 11.
- R5: A pin with mode 2'b11 takes the second term of its bank after the next rising edge. That term is `oe_term[1]` for pins 0 to 5 and `oe_term[3]` for pins 6 to 11.
- R6: The terms of the other bank do not affect a pin's enable.
- R7: While a pin's enable is 1, the pad carries that pin's `pin_out` bit and `pin_in` returns it.
- R8: While a pin's enable is 0, the pad is high impedance and `pin_in` returns the value that an external source drives onto the pad.
- R9: The mode of pin i sits at `pin_mode[2i+1:2i]`, and each pin's enable depends only on its own mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oe_term | input | 4 | Enable terms; bits 1:0 belong to bank 0, bits 3:2 to bank 1 |
| pin_mode | input | 24 | Two-bit mode per pin, pin i at bits 2i+1:2i |
| pin_out | input | 12 | Value each pin drives while enabled |
| pad | inout | 12 | Bidirectional pad lines |
| pin_in | output | 12 | Pad values fed back to the routing matrix |
| pin_oe | output | 12 | Registered driver enables |

## Verification
An enable is due one rising edge after the mode and term values that select it. The bench therefore applies stimulus at a falling edge and compares `pin_oe` at the following falling edge, against a model that it latched when it applied that stimulus. Pad feedback has no register in its path. At each falling edge the bench sets the external drivers to the complement of the expected enables, waits one nanosecond, and compares `pin_in` within the same cycle. It then changes the mode and term inputs.

// File: rtl/banked_oe_pkg.sv
package banked_oe_pkg;

    localparam int TERMS_PER_BANK = 2;
    localparam int MODE_W         = 2;

    typedef enum logic [MODE_W-1:0] {
        DRV_OFF    = 2'b00,
        DRV_ON     = 2'b01,
        DRV_TERM_A = 2'b10,
        DRV_TERM_B = 2'b11
    } drv_mode_e;

    function automatic logic pick_enable(input drv_mode_e mode,
                                         input logic [TERMS_PER_BANK-1:0] terms);
        logic en;
        unique case (mode)
            DRV_OFF:    en = 1'b0;
            DRV_ON:     en = 1'b1;
            DRV_TERM_A: en = terms[0];
            default:    en = terms[1];
        endcase
        return en;
    endfunction

endpackage

// File: rtl/oe_pad_cell.sv
module oe_pad_cell (
    input  logic oe,
    input  logic dout,
    inout  wire  pad,
    output logic din
);
    assign pad = oe ? dout : 1'bz;
    assign din = pad;
endmodule

// File: rtl/oe_bank_ctrl.sv
module oe_bank_ctrl
    import banked_oe_pkg::*;
#(
    parameter int PINS = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TERMS_PER_BANK-1:0]     bank_term,
    input  logic [MODE_W*PINS-1:0]        mode,
    output logic [PINS-1:0]               oe
);
    logic [PINS-1:0] en_next;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        drv_mode_e m;
        assign m = drv_mode_e'(mode[MODE_W*p +: MODE_W]);
        assign en_next[p] = pick_enable(m, bank_term);

        assert_off_R2: assert property (@(posedge clk) disable iff (rst)
            (mode[MODE_W*p +: MODE_W] == 2'b00) |=> !oe[p]);
        assert_on_R3: assert property (@(posedge clk) disable iff (rst)
            (mode[MODE_W*p +: MODE_W] == 2'b01) |=> oe[p]);
        assert_term_a_R4: assert property (@(posedge clk) disable iff (rst)
            (mode[MODE_W*p +: MODE_W] == 2'b10) |=> (oe[p] == $past(bank_term[0])));
        assert_term_b_R5: assert property (@(posedge clk) disable iff (rst)
            (mode[MODE_W*p +: MODE_W] == 2'b11) |=> (oe[p] == $past(bank_term[1])));
    end

    always_ff @(posedge clk) begin
        if (rst) oe <= '0;
        else     oe <= en_next;
    end
endmodule

// File: rtl/banked_oe_ctrl.sv
module banked_oe_ctrl
    import banked_oe_pkg::*;
#(
    parameter int BANKS         = 2,
    parameter int PINS_PER_BANK = 6,
    localparam int NPINS        = BANKS * PINS_PER_BANK,
    localparam int NTERMS       = BANKS * TERMS_PER_BANK
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NTERMS-1:0]       oe_term,
    input  logic [MODE_W*NPINS-1:0] pin_mode,
    input  logic [NPINS-1:0]        pin_out,
    inout  wire  [NPINS-1:0]        pad,
    output logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        pin_oe
);
    localparam int BANK_MODE_W = MODE_W * PINS_PER_BANK;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        oe_bank_ctrl #(.PINS(PINS_PER_BANK)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .bank_term(oe_term[TERMS_PER_BANK*b +: TERMS_PER_BANK]),
            .mode     (pin_mode[BANK_MODE_W*b +: BANK_MODE_W]),
            .oe       (pin_oe[PINS_PER_BANK*b +: PINS_PER_BANK])
        );
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        oe_pad_cell u_cell (
            .oe  (pin_oe[i]),
            .dout(pin_out[i]),
            .pad (pad[i]),
            .din (pin_in[i])
        );

        assert_drive_R7: assert property (@(posedge clk) disable iff (rst)
            pin_oe[i] |-> (pin_in[i] == pin_out[i]));
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0));
endmodule

// File: tb/tb_banked_oe_ctrl.sv
`timescale 1ns/1ps
module tb_banked_oe_ctrl;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    oe_term = '0;
    logic [23:0]   pin_mode = '0;
    logic [NP-1:0] pin_out = '0;
    logic [NP-1:0] ext_en = '1;
    logic [NP-1:0] ext_val = '0;
    wire  [NP-1:0] pad;
    logic [NP-1:0] pin_in, pin_oe;
    logic [NP-1:0] exp_oe;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < NP; i++) begin : g_ext
        assign pad[i] = ext_en[i] ? ext_val[i] : 1'bz;
    end

    banked_oe_ctrl dut (
        .clk(clk), .rst(rst), .oe_term(oe_term), .pin_mode(pin_mode),
        .pin_out(pin_out), .pad(pad), .pin_in(pin_in), .pin_oe(pin_oe)
    );

    function automatic logic [NP-1:0] model_oe(input logic [23:0] md, input logic [3:0] t);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic [1:0] m;
            int bk;
            m  = md[2*i +: 2];
            bk = (i < 6) ? 0 : 1;
            case (m)
                2'b00:   r[i] = 1'b0;
                2'b01:   r[i] = 1'b1;
                2'b10:   r[i] = t[2*bk];
                default: r[i] = t[2*bk+1];
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply inputs at a falling edge; model latched for the next edge
    task automatic apply(input logic [23:0] md, input logic [3:0] t);
        pin_mode = md;
        oe_term  = t;
        exp_oe   = model_oe(md, t);
    endtask

    // at a falling edge: check enables, then pad feedback
    task automatic observe(input string tag);
        logic [NP-1:0] o, e;
        o = NP'($urandom);
        e = NP'($urandom);
        check(tag, pin_oe, exp_oe);
        pin_out = o;
        ext_val = e;
        ext_en  = ~exp_oe;
        #1;
        check("R7/R8 pad feedback", pin_in, (exp_oe & o) | (~exp_oe & e));
    endtask

    function automatic logic [23:0] all_mode(input logic [1:0] m);
        logic [23:0] r;
        for (int i = 0; i < NP; i++) r[2*i +: 2] = m;
        return r;
    endfunction

    initial begin
        void'($urandom(32'd2718));
        exp_oe = '0;
        // R1: reset with modes that would otherwise turn pins on
        pin_mode = all_mode(2'b01);
        oe_term  = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        observe("R1 reset clears enables");
        rst = 1'b0;

        // R2, R3: forced modes
        apply(all_mode(2'b00), 4'hF);
        @(negedge clk); observe("R2 forced off");
        apply(all_mode(2'b01), 4'h0);
        @(negedge clk); observe("R3 forced on");

        // R4, R5: term modes per bank
        apply(all_mode(2'b10), 4'b0001);
        @(negedge clk); observe("R4 first term bank0 only");
        apply(all_mode(2'b10), 4'b0100);
        @(negedge clk); observe("R4 first term bank1 only");
        apply(all_mode(2'b11), 4'b0010);
        @(negedge clk); observe("R5 second term bank0 only");
        apply(all_mode(2'b11), 4'b1000);
        @(negedge clk); observe("R5 second term bank1 only");

        // R6: other bank's terms toggle, bank0 term A held at 1
        begin
            logic [23:0] md;
            md = '0;
            for (int i = 0; i < 6; i++) md[2*i +: 2] = 2'b10;
            apply(md, 4'b0001);
            @(negedge clk); observe("R6 baseline");
            apply(md, 4'b1101);
            @(negedge clk); observe("R6 bank1 terms ignored by bank0");
            check("R6 bank0 enables stay", pin_oe[5:0], 6'h3F);
        end

        // R9: mixed per-pin fields
        apply(24'b11_10_01_00_11_10_01_00_11_10_01_00, 4'b1001);
        @(negedge clk); observe("R9 per-pin field decode");
        apply(24'b00_01_10_11_00_01_10_11_00_01_10_11, 4'b0110);
        @(negedge clk); observe("R9 per-pin field decode reversed");

        // random mix, R2..R8
        for (int k = 0; k < 300; k++) begin
            apply(24'($urandom), 4'($urandom));
            @(negedge clk); observe("R2-R5 random enable");
        end

        // R1 again mid-run
        rst = 1'b1;
        apply(all_mode(2'b01), 4'hF);
        exp_oe = '0;
        @(negedge clk); observe("R1 reset mid-run");
        rst = 1'b0;
        apply(all_mode(2'b01), 4'h0);
        @(negedge clk); observe("R3 after reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule